// File: doc/BRIEF.md
# Head Seek and Step Controller

This block runs the head-positioning commands of a floppy disk controller. The host writes a command byte; whenever bit 7 of that byte is clear the block takes it as a positioning command and decodes bits 6:4 as the operation. It then moves the drive head one track at a time. Each move is a single-clock step pulse, given together with a direction level. Between moves the block waits a programmable number of millisecond ticks. It keeps a track register holding where it believes the head is. It also keeps a target register, which the seek command compares against the track register.

A restore command finds track zero. It forces the track register to 0xFF and the target to 0x00, then seeks outward until the track-zero sensor reports the head has arrived. A seek command walks toward the target and stops when the two registers match. The three step commands each take exactly one step. Step-in first sets the direction inward, step-out first sets it outward, and plain step keeps the last direction. A command marks the block busy. When it completes, busy drops and an interrupt request is raised. A new command written while one is running abandons the running one.

Top module: `headSeekCtrl`

## Requirements
- R1: After reset busy, irq and stepPulse are 0, trackReg and dataReg are 0x00 and stepDirIn is 1 (inward).
- R2: A write of a command byte with bit 7 clear sets busy and clears irq at the next clock edge. A byte with bit 7 set has no effect on any output.
- R3: Restore (bits 6:4 = 000) sets trackReg to 0xFF and dataReg to 0x00, then behaves as a seek toward 0x00.
- R4: Seek and restore have bits 6:4 = 000 or 001. They end without a step pulse when trackReg equals dataReg. Otherwise each pass sets the direction inward if dataReg > trackReg (unsigned) and outward if not. It adds one to trackReg for an inward move, subtracts one for an outward move, and issues one step pulse. After each interval the comparison runs again.
- R5: The wait after a step pulse lasts 6, 12, 20 or 30 msTick pulses, selected by command bits 1:0 = 0, 1, 2 or 3.
- R6: Step (bits 6:4 = 01x), step-in (10x) and step-out (11x) issue exactly one pulse and then finish when the interval ends. Step-in sets stepDirIn to 1, step-out sets it to 0, and plain step keeps it. Bit 4 set means trackReg follows the move; bit 4 clear leaves trackReg unchanged.
- R7: If a pass would move outward while trackZero is 1, trackReg becomes 0x00, no pulse is issued and the command ends.
- R8: At completion busy falls and irq rises on the same clock edge. irq then stays high until the next accepted command.
- R9: An accepted command written while another is running abandons the running one at once, and no further pulse comes from the old command.
- R10: stepPulse is high for one clock at a time, and stepDirIn holds its value during the clock after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrite | input | 1 | Command byte write strobe |
| cmdByte | input | 8 | Command byte |
| trackWrite | input | 1 | Host write strobe for the track register |
| trackByte | input | 8 | Value for the track register |
| dataWrite | input | 1 | Host write strobe for the target register |
| dataByte | input | 8 | Target track value |
| msTick | input | 1 | One-clock enable once per millisecond |
| trackZero | input | 1 | Drive reports the head is at track zero |
| stepPulse | output | 1 | One-clock step request to the drive |
| stepDirIn | output | 1 | Step direction, 1 = inward |
| busy | output | 1 | Command in progress |
| irq | output | 1 | Completion interrupt request |
| trackReg | output | 8 | Current track register |
| dataReg | output | 8 | Target register |

## Verification
A seek toward a higher target checks that the direction and the track updates follow the unsigned comparison. A restore from a nonzero head position checks that the track-zero sensor, and not the register count, ends the command. Single steps are run with bit 4 set and clear, and with each direction form, to separate the direction latch from track updates. Every rate code is timed. Further cases cover a target that is already reached, a step outward while already at track zero, a command that interrupts a running one, and bytes with bit 7 set, which must leave the outputs untouched.

// File: rtl/headSeekPkg.sv
package headSeekPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_WAIT = 2'd2
  } seekState_t;

  typedef struct packed {
    logic       loadRestore;
    logic       dirLoad;
    logic       dirVal;
    logic       trackInc;
    logic       trackDec;
    logic       clrTrack;
    logic       cntLoad;
    logic       cntDec;
    logic [1:0] rate;
  } dpCtrl_t;

endpackage

// File: rtl/headSeekDatapath.sv
module headSeekDatapath
  import headSeekPkg::*;
#(
  parameter int TRACK_W   = 8,
  parameter int STEP_MS_A = 6,
  parameter int STEP_MS_B = 12,
  parameter int STEP_MS_C = 20,
  parameter int STEP_MS_D = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctrl,
  input  logic               hostTrackWr,
  input  logic [TRACK_W-1:0] hostTrackVal,
  input  logic               hostDataWr,
  input  logic [TRACK_W-1:0] hostDataVal,
  output logic [TRACK_W-1:0] trackReg,
  output logic [TRACK_W-1:0] dataReg,
  output logic               dirIn,
  output logic               trackEqData,
  output logic               dataGtTrack,
  output logic               cntLast
);

  localparam int MAX_AB = (STEP_MS_A > STEP_MS_B) ? STEP_MS_A : STEP_MS_B;
  localparam int MAX_CD = (STEP_MS_C > STEP_MS_D) ? STEP_MS_C : STEP_MS_D;
  localparam int MAX_MS = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_MS + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    case (ctrl.rate)
      2'd0:    loadVal = CNT_W'(STEP_MS_A);
      2'd1:    loadVal = CNT_W'(STEP_MS_B);
      2'd2:    loadVal = CNT_W'(STEP_MS_C);
      default: loadVal = CNT_W'(STEP_MS_D);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (ctrl.cntLoad) cnt <= loadVal;
    else if (ctrl.cntDec)  cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 trackReg <= '0;
    else if (ctrl.loadRestore) trackReg <= '1;
    else if (ctrl.clrTrack)    trackReg <= '0;
    else if (ctrl.trackInc)    trackReg <= trackReg + TRACK_W'(1);
    else if (ctrl.trackDec)    trackReg <= trackReg - TRACK_W'(1);
    else if (hostTrackWr)      trackReg <= hostTrackVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 dataReg <= '0;
    else if (ctrl.loadRestore) dataReg <= '0;
    else if (hostDataWr)       dataReg <= hostDataVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             dirIn <= 1'b1;
    else if (ctrl.dirLoad) dirIn <= ctrl.dirVal;
  end

  assign trackEqData = (trackReg == dataReg);
  assign dataGtTrack = (dataReg > trackReg);
  assign cntLast     = (cnt == CNT_W'(1));

  // R3: restore forces the register pair
  assert_restore_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadRestore |=> (trackReg == '1) && (dataReg == '0));

  // R7: track-zero arrival clears the track register
  assert_zero_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrTrack |=> (trackReg == '0));

  // R5: a freshly loaded interval is never the last tick unless it is one
  assert_cnt_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cntLoad && (loadVal > CNT_W'(1)) |=> !cntLast);

endmodule

// File: rtl/headSeekControl.sv
module headSeekControl
  import headSeekPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrite,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [1:0] cmdRate,
  input  logic       msTick,
  input  logic       trackZero,
  input  logic       trackEqData,
  input  logic       dataGtTrack,
  input  logic       dirIn,
  input  logic       cntLast,
  output dpCtrl_t    ctrl,
  output logic       stepPulse,
  output logic       busy,
  output logic       irq
);

  seekState_t state, stateN;
  logic [2:0] opReg;
  logic [1:0] rateReg;
  logic       busyN, irqN, pulseN;
  logic       seekLike, updTrack, newDir, accept;

  assign accept   = cmdWrite && cmdValid;
  assign seekLike = (opReg[2:1] == 2'b00);
  assign updTrack = seekLike || opReg[0];
  assign newDir   = seekLike ? dataGtTrack : dirIn;

  always_comb begin
    ctrl      = '0;
    ctrl.rate = rateReg;
    stateN    = state;
    busyN     = busy;
    irqN      = irq;
    pulseN    = 1'b0;
    if (accept) begin
      stateN = ST_EVAL;
      busyN  = 1'b1;
      irqN   = 1'b0;
      case (cmdOp)
        3'd0:       ctrl.loadRestore = 1'b1;
        3'd4, 3'd5: begin ctrl.dirLoad = 1'b1; ctrl.dirVal = 1'b1; end
        3'd6, 3'd7: begin ctrl.dirLoad = 1'b1; ctrl.dirVal = 1'b0; end
        default:    ;
      endcase
    end else begin
      case (state)
        ST_EVAL: begin
          if (seekLike && trackEqData) begin
            stateN = ST_IDLE;
            busyN  = 1'b0;
            irqN   = 1'b1;
          end else begin
            ctrl.dirLoad  = seekLike;
            ctrl.dirVal   = dataGtTrack;
            ctrl.trackInc = updTrack && newDir;
            ctrl.trackDec = updTrack && !newDir;
            if (!newDir && trackZero) begin
              ctrl.clrTrack = 1'b1;
              stateN        = ST_IDLE;
              busyN         = 1'b0;
              irqN          = 1'b1;
            end else begin
              pulseN       = 1'b1;
              ctrl.cntLoad = 1'b1;
              stateN       = ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (msTick) begin
            if (cntLast) begin
              if (seekLike) begin
                stateN = ST_EVAL;
              end else begin
                stateN = ST_IDLE;
                busyN  = 1'b0;
                irqN   = 1'b1;
              end
            end else begin
              ctrl.cntDec = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      opReg     <= '0;
      rateReg   <= '0;
      busy      <= 1'b0;
      irq       <= 1'b0;
      stepPulse <= 1'b0;
    end else begin
      state     <= stateN;
      busy      <= busyN;
      irq       <= irqN;
      stepPulse <= pulseN;
      if (accept) begin
        opReg   <= cmdOp;
        rateReg <= cmdRate;
      end
    end
  end

  // R2: an accepted command starts busy with irq cleared
  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy && !irq);

  // R2: a byte with bit 7 set while idle leaves the block idle
  assert_ignore_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrite && !cmdValid && !busy |=> !busy);

  // R8: completion raises the interrupt as busy drops
  assert_end_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);

  // R10: pulses are single cycles
  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse |=> !stepPulse);

  // R10: direction holds in the cycle after the pulse
  assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse && !accept |=> $stable(dirIn));

  // R6: a pulse only occurs within a command
  assert_pulse_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    stepPulse |-> busy);

endmodule

// File: rtl/headSeekCtrl.sv
module headSeekCtrl
  import headSeekPkg::*;
#(
  parameter int TRACK_W   = 8,
  parameter int STEP_MS_A = 6,
  parameter int STEP_MS_B = 12,
  parameter int STEP_MS_C = 20,
  parameter int STEP_MS_D = 30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdWrite,
  input  logic [7:0]         cmdByte,
  input  logic               trackWrite,
  input  logic [TRACK_W-1:0] trackByte,
  input  logic               dataWrite,
  input  logic [TRACK_W-1:0] dataByte,
  input  logic               msTick,
  input  logic               trackZero,
  output logic               stepPulse,
  output logic               stepDirIn,
  output logic               busy,
  output logic               irq,
  output logic [TRACK_W-1:0] trackReg,
  output logic [TRACK_W-1:0] dataReg
);

  dpCtrl_t    ctrl;
  logic       trackEqData, dataGtTrack, cntLast;
  logic [1:0] unusedFlags;

  assign unusedFlags = cmdByte[3:2];

  headSeekControl ctl_i (
    .clk         (clk),
    .rstN        (rstN),
    .cmdWrite    (cmdWrite),
    .cmdValid    (!cmdByte[7]),
    .cmdOp       (cmdByte[6:4]),
    .cmdRate     (cmdByte[1:0]),
    .msTick      (msTick),
    .trackZero   (trackZero),
    .trackEqData (trackEqData),
    .dataGtTrack (dataGtTrack),
    .dirIn       (stepDirIn),
    .cntLast     (cntLast),
    .ctrl        (ctrl),
    .stepPulse   (stepPulse),
    .busy        (busy),
    .irq         (irq)
  );

  headSeekDatapath #(
    .TRACK_W   (TRACK_W),
    .STEP_MS_A (STEP_MS_A),
    .STEP_MS_B (STEP_MS_B),
    .STEP_MS_C (STEP_MS_C),
    .STEP_MS_D (STEP_MS_D)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .hostTrackWr  (trackWrite),
    .hostTrackVal (trackByte),
    .hostDataWr   (dataWrite),
    .hostDataVal  (dataByte),
    .trackReg     (trackReg),
    .dataReg      (dataReg),
    .dirIn        (stepDirIn),
    .trackEqData  (trackEqData),
    .dataGtTrack  (dataGtTrack),
    .cntLast      (cntLast)
  );

endmodule

// File: tb/headSeekCtrl_tb_top.sv
`timescale 1ns/1ps
module headSeekCtrl_tb_top;

  localparam int TICK_DIV = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdWrite = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic       trackWrite = 1'b0;
  logic [7:0] trackByte = 8'h00;
  logic       dataWrite = 1'b0;
  logic [7:0] dataByte = 8'h00;
  logic       msTick = 1'b0;
  logic       trackZero = 1'b0;
  logic       stepPulse, stepDirIn, busy, irq;
  logic [7:0] trackReg, dataReg;

  always #5 clk = ~clk;

  headSeekCtrl dut_i (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdByte(cmdByte),
    .trackWrite(trackWrite), .trackByte(trackByte),
    .dataWrite(dataWrite), .dataByte(dataByte),
    .msTick(msTick), .trackZero(trackZero),
    .stepPulse(stepPulse), .stepDirIn(stepDirIn), .busy(busy), .irq(irq),
    .trackReg(trackReg), .dataReg(dataReg)
  );

  integer checks = 0;
  integer fails = 0;
  integer cyc = 0;
  integer headPos = 3;
  integer pulses = 0;
  integer pulseCyc = 0;
  integer fallCyc = 0;
  integer tickCnt = 0;
  logic   prevBusy = 1'b0;
  bit     done = 1'b0;

  // reference model state
  logic       mBusy, mIrq, mPulse, mDir;
  logic [7:0] mTrack, mData;
  logic [7:0] mCmd;
  integer     mPhase, mLeft;
  logic       mSeek;

  function automatic integer msOf(input logic [1:0] r);
    case (r)
      2'd0: msOf = 6;
      2'd1: msOf = 12;
      2'd2: msOf = 20;
      default: msOf = 30;
    endcase
  endfunction

  task automatic mFinish();
    mBusy = 1'b0; mIrq = 1'b1; mPhase = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mIrq = 0; mPulse = 0; mDir = 1; mTrack = 0; mData = 0;
      mCmd = 0; mPhase = 0; mLeft = 0;
    end else begin
      logic np;
      np = 1'b0;
      if (cmdWrite && !cmdByte[7]) begin
        mCmd = cmdByte; mBusy = 1; mIrq = 0; mPhase = 1;
        if (cmdByte[6:4] == 3'd0) begin mTrack = 8'hFF; mData = 8'h00; end
        if (cmdByte[6:5] == 2'b10) mDir = 1;
        if (cmdByte[6:5] == 2'b11) mDir = 0;
      end else begin
        if (trackWrite) mTrack = trackByte;
        if (dataWrite) mData = dataByte;
        mSeek = (mCmd[6:4] < 3'd2);
        if (mPhase == 1) begin
          if (mSeek && mTrack == mData) mFinish();
          else begin
            if (mSeek) mDir = (mData > mTrack);
            if (mSeek || mCmd[4]) mTrack = mDir ? mTrack + 8'd1 : mTrack - 8'd1;
            if (!mDir && trackZero) begin mTrack = 0; mFinish(); end
            else begin np = 1'b1; mLeft = msOf(mCmd[1:0]); mPhase = 2; end
          end
        end else if (mPhase == 2 && msTick) begin
          mLeft = mLeft - 1;
          if (mLeft == 0) begin
            if (mSeek) mPhase = 1; else mFinish();
          end
        end
      end
      mPulse = np;
    end
  end

  // per-cycle comparison, drive model, tick source, watchdog
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rstN && !done) begin
      checks = checks + 1;
      if (busy !== mBusy) begin fails++; $display("FAIL R2 R8 busy act=%0b exp=%0b cyc=%0d", busy, mBusy, cyc); end
      if (irq !== mIrq) begin fails++; $display("FAIL R8 irq act=%0b exp=%0b cyc=%0d", irq, mIrq, cyc); end
      if (stepPulse !== mPulse) begin fails++; $display("FAIL R4 R5 R6 R9 stepPulse act=%0b exp=%0b cyc=%0d", stepPulse, mPulse, cyc); end
      if (stepDirIn !== mDir) begin fails++; $display("FAIL R6 R10 stepDirIn act=%0b exp=%0b cyc=%0d", stepDirIn, mDir, cyc); end
      if (trackReg !== mTrack) begin fails++; $display("FAIL R3 R4 R7 trackReg act=%0h exp=%0h cyc=%0d", trackReg, mTrack, cyc); end
      if (dataReg !== mData) begin fails++; $display("FAIL R3 dataReg act=%0h exp=%0h cyc=%0d", dataReg, mData, cyc); end
    end
    if (stepPulse) begin
      pulses = pulses + 1;
      pulseCyc = cyc;
      headPos = stepDirIn ? headPos + 1 : headPos - 1;
    end
    if (prevBusy && !busy) fallCyc = cyc;
    prevBusy = busy;
    trackZero = (headPos == 0);
    tickCnt = (tickCnt + 1) % TICK_DIV;
    msTick = (tickCnt == 0);
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      checks = checks + 1; fails = fails + 1;
      $display("FAIL watchdog act=%0d exp<190000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input integer act, input integer exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] b);
    @(negedge clk); cmdWrite = 1'b1; cmdByte = b;
    @(negedge clk); cmdWrite = 1'b0;
  endtask

  task automatic setData(input logic [7:0] v);
    @(negedge clk); dataWrite = 1'b1; dataByte = v;
    @(negedge clk); dataWrite = 1'b0;
  endtask

  task automatic setTrack(input logic [7:0] v);
    @(negedge clk); trackWrite = 1'b1; trackByte = v;
    @(negedge clk); trackWrite = 1'b0;
  endtask

  task automatic waitIdle();
    #1;
    while (busy) begin @(negedge clk); #1; end
  endtask

  initial begin
    integer p0, dur;
    repeat (4) @(negedge clk);
    #1;
    check(busy == 0 && irq == 0 && stepPulse == 0, "R1 reset controls", {busy, irq, stepPulse}, 0);
    check(trackReg == 0 && dataReg == 0, "R1 reset registers", trackReg, 0);
    check(stepDirIn == 1, "R1 reset direction", stepDirIn, 1);
    @(negedge clk); rstN = 1'b1;

    // seek inward by two
    setTrack(8'd3);
    setData(8'd5);
    p0 = pulses;
    issue(8'h10);
    #1; check(busy == 1 && irq == 0, "R2 start busy", busy, 1);
    waitIdle();
    check(pulses - p0 == 2, "R4 seek pulses", pulses - p0, 2);
    check(trackReg == 5, "R4 seek track", trackReg, 5);
    check(irq == 1, "R8 irq after seek", irq, 1);

    // timing of each rate code with step-in, track updated
    for (int r = 0; r < 4; r++) begin
      p0 = pulses;
      issue(8'h50 | 8'(r));
      waitIdle();
      dur = fallCyc - pulseCyc;
      check(pulses - p0 == 1, "R6 step-in single pulse", pulses - p0, 1);
      check(dur >= msOf(2'(r)) * TICK_DIV - 3 && dur <= msOf(2'(r)) * TICK_DIV + 1,
            "R5 interval length", dur, msOf(2'(r)) * TICK_DIV);
    end
    check(trackReg == 9, "R6 step-in track follows", trackReg, 9);

    issue(8'h70); waitIdle();
    check(trackReg == 8 && stepDirIn == 0, "R6 step-out with update", trackReg, 8);
    p0 = pulses;
    issue(8'h30); waitIdle();
    check(stepDirIn == 0 && pulses - p0 == 1, "R6 plain step reuses direction", stepDirIn, 0);
    check(trackReg == 7, "R6 plain step update", trackReg, 7);
    p0 = pulses;
    issue(8'h20); waitIdle();
    check(trackReg == 7 && pulses - p0 == 1, "R6 step without update", trackReg, 7);
    issue(8'h40); waitIdle();
    check(trackReg == 7 && stepDirIn == 1, "R6 step-in without update", trackReg, 7);

    // restore from head position 7
    p0 = pulses;
    issue(8'h00); waitIdle();
    check(pulses - p0 == 7, "R3 restore pulses", pulses - p0, 7);
    check(trackReg == 0 && dataReg == 0, "R3 R7 restore registers", trackReg, 0);

    // step-out at track zero
    p0 = pulses;
    issue(8'h70); waitIdle();
    check(pulses - p0 == 0 && trackReg == 0, "R7 no step at track zero", pulses - p0, 0);
    check(irq == 1, "R7 R8 irq at track zero", irq, 1);

    // seek already on target
    p0 = pulses;
    issue(8'h10); waitIdle();
    check(pulses - p0 == 0 && trackReg == 0, "R4 seek on target", pulses - p0, 0);

    // abort a long seek with a step-in without update
    setData(8'd20);
    p0 = pulses;
    issue(8'h13);
    while (pulses == p0) @(negedge clk);
    repeat (10) @(negedge clk);
    issue(8'h40); waitIdle();
    check(pulses - p0 == 2, "R9 abort pulse count", pulses - p0, 2);
    check(trackReg == 1, "R9 abort track", trackReg, 1);

    // bytes with bit 7 set are ignored
    issue(8'h80); repeat (3) @(negedge clk); #1;
    check(busy == 0 && irq == 1 && trackReg == 1 && stepPulse == 0, "R2 ignored 0x80", {busy, irq}, 1);
    issue(8'hD0); repeat (3) @(negedge clk); #1;
    check(busy == 0 && irq == 1 && dataReg == 20, "R2 ignored 0xD0", dataReg, 20);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule